// File: doc/BRIEF.md
# Universal Binary/Decimal Sign-Magnitude Adder

This block adds or subtracts two operands that are either plain binary words or packed decimal words (four bits per digit). A mode input says whether each operand is an unsigned magnitude or a sign-magnitude number whose top bit is the sign. The unit looks at the two signs and the requested operation to decide whether the magnitudes must really be added or subtracted. It then produces a true sign-magnitude result, never a complement form, together with an overflow flag.

Subtraction complements the subtrahend: one's complement in binary mode and nine's complement in decimal mode. Both candidate sums, with carry-in 0 and 1, are formed side by side. The carry out of the carry-in-0 sum tells which magnitude was larger. That carry selects either the carry-in-1 sum (end-around carry) or the recomplemented carry-in-0 sum. Decimal digits receive a +6 correction whenever their binary digit sum exceeds nine. The datapath has two register stages and accepts a new operation every clock.

Top module: `ubcd_addsub`

## Requirements
- R1: With `signed_i`=1, bit W-1 of each operand is its sign and bits W-2..0 its magnitude. With `signed_i`=0, both signs are taken as 0 and all W bits form the magnitude.
- R2: The magnitudes are effectively subtracted when sign(A) XOR sign(B) XOR `sub_i` is 1. Otherwise they are effectively added.
- R3: With `bin_i`=1 and effective addition, the result magnitude is (|A|+|B|) mod 2^W, as plain binary with no decimal correction.
- R4: With `bin_i`=1 and effective subtraction, the result magnitude is the true value of ||A|-|B||.
- R5: With `bin_i`=0, every 4-bit digit is BCD (digit 0 is bits 3..0). Effective addition gives the decimal sum modulo 10^NDIG, and every digit stays in 0..9.
- R6: With `bin_i`=0 and effective subtraction, the result is the true decimal value of ||A|-|B||.
- R7: The result sign is sign(A), except in one case: an effective subtraction with |A|<|B| gives the inverse of sign(A).
- R8: A result whose magnitude field is zero and which has no overflow always has sign 0.
- R9: `ovf_o` can be set only on effective addition. It is set when the sum does not fit the magnitude field. For binary the limit is 2^(W-1) when signed and 2^W when unsigned. For decimal the limit is 8*10^(NDIG-1) when signed and 10^NDIG when unsigned. An overflow leaves the sign rule of R7 unchanged.
- R10: An operation presented with `valid_i` high shows its result with `valid_o` high exactly two clocks later. Operations may be issued every cycle, and after reset `valid_o` is 0.
- R11: With `signed_i`=1, `res_o` is {sign, magnitude[W-2:0]}. With `signed_i`=0, `res_o` is the full W-bit magnitude. `sign_o` always carries the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present |
| op_a_i | input | W | Operand A (minuend) |
| op_b_i | input | W | Operand B |
| sub_i | input | 1 | Requested operation: 0 add, 1 subtract |
| signed_i | input | 1 | 1: sign-magnitude operands, 0: unsigned |
| bin_i | input | 1 | 1: binary, 0: packed BCD |
| valid_o | output | 1 | Result present |
| res_o | output | W | Result word |
| sign_o | output | 1 | Result sign |
| ovf_o | output | 1 | Magnitude overflow on effective addition |

## Verification
Recomplement and sign inversion both happen in the same cycle when an effective subtraction finds |A|<|B|. Zero forcing joins them when the magnitudes are equal. The bench sweeps operand pairs that include equal magnitudes and every combination of sign bits and operation, so that the smaller-minuend case and the equal case are hit in both number systems. Each result is compared with a value computed arithmetically from integer magnitudes. Overflow and zero also coincide in one family of cases: an effective addition whose sum wraps to exactly zero in the field (such as 64+64 in a signed 8-bit word). This must keep sign(A) and raise the flag, and the bench judges it the same way.

// File: rtl/ubcd_pkg.sv
package ubcd_pkg;

  typedef struct packed {
    logic eff_sub;
    logic sgn_a;
    logic smode;
    logic bin;
  } ctl_t;

  // 9 - d for a BCD digit: invert, then subtract six
  function automatic logic [3:0] nines(input logic [3:0] d);
    return 4'(~d) - 4'd6;
  endfunction

endpackage

// File: rtl/ubcd_digit.sv
module ubcd_digit (
  input  logic [3:0] x_i,
  input  logic [3:0] y_i,
  input  logic       c_i,
  input  logic       dec_i,
  output logic [3:0] s_o,
  output logic       c_o
);
  logic [4:0] raw;
  logic       fix;

  always_comb begin
    raw = {1'b0, x_i} + {1'b0, y_i} + {4'b0, c_i};
    fix = dec_i && (raw > 5'd9);
    s_o = fix ? 4'(raw + 5'd6) : raw[3:0];
    c_o = fix | raw[4];
  end
endmodule

// File: rtl/ubcd_chain.sv
module ubcd_chain #(
  parameter int NDIG = 8,
  localparam int W = 4 * NDIG
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  input  logic         dec_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [NDIG:0] cy;
  assign cy[0] = c_i;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    ubcd_digit u_dig (
      .x_i  (x_i[4*g +: 4]),
      .y_i  (y_i[4*g +: 4]),
      .c_i  (cy[g]),
      .dec_i(dec_i),
      .s_o  (s_o[4*g +: 4]),
      .c_o  (cy[g+1])
    );
  end

  assign c_o = cy[NDIG];
endmodule

// File: rtl/ubcd_prep.sv
module ubcd_prep
  import ubcd_pkg::*;
#(
  parameter int NDIG = 8,
  localparam int W = 4 * NDIG
) (
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic         sub_i,
  input  logic         signed_i,
  input  logic         bin_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] opnd_b_o,
  output ctl_t         ctl_o
);
  logic         sa, sb, esub;
  logic [W-1:0] mb, b_nine;

  assign sa      = op_a_i[W-1] & signed_i;
  assign sb      = op_b_i[W-1] & signed_i;
  assign esub    = sa ^ sb ^ sub_i;
  assign mag_a_o = signed_i ? {1'b0, op_a_i[W-2:0]} : op_a_i;
  assign mb      = signed_i ? {1'b0, op_b_i[W-2:0]} : op_b_i;

  for (genvar g = 0; g < NDIG; g++) begin : g_nine
    assign b_nine[4*g +: 4] = nines(mb[4*g +: 4]);
  end

  assign opnd_b_o = !esub ? mb : (bin_i ? ~mb : b_nine);
  assign ctl_o    = '{eff_sub: esub, sgn_a: sa, smode: signed_i, bin: bin_i};
endmodule

// File: rtl/ubcd_core.sv
module ubcd_core
  import ubcd_pkg::*;
#(
  parameter int NDIG = 8,
  localparam int W = 4 * NDIG
) (
  input  logic [W-1:0] mag_a_i,
  input  logic [W-1:0] opnd_b_i,
  input  ctl_t         ctl_i,
  output logic [W-1:0] res_o,
  output logic         sign_o,
  output logic         ovf_o
);
  logic [W-1:0] sum_c0, sum_c1, recomp, mag;
  logic         cout_c0, cout_c1, fzero, zero;

  // both carry-in candidates in parallel; cout_c0 picks
  ubcd_chain #(.NDIG(NDIG)) u_c0 (
    .x_i(mag_a_i), .y_i(opnd_b_i), .c_i(1'b0), .dec_i(~ctl_i.bin),
    .s_o(sum_c0), .c_o(cout_c0)
  );
  ubcd_chain #(.NDIG(NDIG)) u_c1 (
    .x_i(mag_a_i), .y_i(opnd_b_i), .c_i(1'b1), .dec_i(~ctl_i.bin),
    .s_o(sum_c1), .c_o(cout_c1)
  );

  logic [W-1:0] sum_nine;
  for (genvar g = 0; g < NDIG; g++) begin : g_rc
    assign sum_nine[4*g +: 4] = nines(sum_c0[4*g +: 4]);
  end

  assign recomp = ctl_i.bin ? ~sum_c0 : sum_nine;

  always_comb begin
    if (!ctl_i.eff_sub)  mag = sum_c0;
    else if (cout_c0)    mag = sum_c1;
    else                 mag = recomp;
    ovf_o  = !ctl_i.eff_sub && (cout_c0 || (ctl_i.smode && mag[W-1]));
    fzero  = ctl_i.smode ? (mag[W-2:0] == '0) : (mag == '0);
    zero   = fzero && !ovf_o;
    sign_o = zero ? 1'b0 : ((ctl_i.eff_sub && !cout_c0) ? ~ctl_i.sgn_a : ctl_i.sgn_a);
    res_o  = ctl_i.smode ? {sign_o, mag[W-2:0]} : mag;
  end

  logic unused_c1;
  assign unused_c1 = cout_c1;
endmodule

// File: rtl/ubcd_addsub.sv
module ubcd_addsub
  import ubcd_pkg::*;
#(
  parameter int NDIG = 8,
  localparam int W = 4 * NDIG
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic         sub_i,
  input  logic         signed_i,
  input  logic         bin_i,
  output logic         valid_o,
  output logic [W-1:0] res_o,
  output logic         sign_o,
  output logic         ovf_o
);
  logic [W-1:0] pa_d, pb_d, pa_q, pb_q, res_d;
  ctl_t         ctl_d, ctl_q;
  logic         vld_q, sign_d, ovf_d;

  ubcd_prep #(.NDIG(NDIG)) u_prep (
    .op_a_i, .op_b_i, .sub_i, .signed_i, .bin_i,
    .mag_a_o(pa_d), .opnd_b_o(pb_d), .ctl_o(ctl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q <= '0; pb_q <= '0; ctl_q <= '0; vld_q <= 1'b0;
    end else begin
      pa_q <= pa_d; pb_q <= pb_d; ctl_q <= ctl_d; vld_q <= valid_i;
    end
  end

  ubcd_core #(.NDIG(NDIG)) u_core (
    .mag_a_i(pa_q), .opnd_b_i(pb_q), .ctl_i(ctl_q),
    .res_o(res_d), .sign_o(sign_d), .ovf_o(ovf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; res_o <= '0; sign_o <= 1'b0; ovf_o <= 1'b0;
    end else begin
      valid_o <= vld_q; res_o <= res_d; sign_o <= sign_d; ovf_o <= ovf_d;
    end
  end
endmodule

// File: rtl/ubcd_addsub_chk.sv
module ubcd_addsub_chk #(
  parameter int NDIG = 8,
  localparam int W = 4 * NDIG
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         sa_i,
  input logic         sb_i,
  input logic         sub_i,
  input logic         signed_i,
  input logic         bin_i,
  input logic         valid_o,
  input logic [W-1:0] res_o,
  input logic         sign_o,
  input logic         ovf_o
);
  logic v1, v2, ea1, ea2, sm1, sm2, bn1, bn2;
  logic eff_add_in;
  assign eff_add_in = !((sa_i & signed_i) ^ (sb_i & signed_i) ^ sub_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 0; v2 <= 0; ea1 <= 0; ea2 <= 0; sm1 <= 0; sm2 <= 0; bn1 <= 0; bn2 <= 0;
    end else begin
      v1 <= valid_i; v2 <= v1;
      ea1 <= eff_add_in; ea2 <= ea1;
      sm1 <= signed_i; sm2 <= sm1;
      bn1 <= bin_i; bn2 <= bn1;
    end
  end

  function automatic logic digits_ok(input logic [W-1:0] r, input logic sm);
    logic ok = 1'b1;
    for (int i = 0; i < NDIG - 1; i++) if (r[4*i +: 4] > 4'd9) ok = 1'b0;
    if (!sm && r[W-1 -: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R10
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v2);

  // R8
  no_neg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ovf_o && sign_o) |->
      (sm2 ? (res_o[W-2:0] != '0) : (res_o != '0)));

  // R9
  ovf_on_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovf_o) |-> ea2);

  // R5
  bcd_digit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !bn2) |-> digits_ok(res_o, sm2));

  // R7
  unsigned_add_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !sm2 && ea2) |-> !sign_o);

  // R11
  sign_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sm2) |-> (res_o[W-1] == sign_o));
endmodule

bind ubcd_addsub ubcd_addsub_chk #(.NDIG(NDIG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .sa_i(op_a_i[W-1]), .sb_i(op_b_i[W-1]), .sub_i(sub_i),
  .signed_i(signed_i), .bin_i(bin_i), .valid_o(valid_o),
  .res_o(res_o), .sign_o(sign_o), .ovf_o(ovf_o)
);

// File: tb/ubcd_addsub_bench.sv
module ubcd_addsub_bench;
  localparam int CLK_PER = 10;
  localparam int ND = 2;
  localparam int WT = 4 * ND;

  typedef struct {
    logic [WT-1:0] res;
    logic          sign;
    logic          ovf;
    bit            bin;
    bit            sub;
    bit            zero;
  } exp_t;

  logic          clk = 0, rst_ni = 0, valid_i = 0, sub_i = 0, signed_i = 0, bin_i = 0;
  logic [WT-1:0] op_a_i = '0, op_b_i = '0;
  logic          valid_o, sign_o, ovf_o;
  logic [WT-1:0] res_o;

  int   total = 0, bad = 0;
  bit   vh0 = 0, vh1 = 0;
  exp_t q[$];

  always #(CLK_PER/2) clk = ~clk;

  ubcd_addsub #(.NDIG(ND)) u_ubcd_addsub (
    .clk_i(clk), .rst_ni, .valid_i, .op_a_i, .op_b_i, .sub_i, .signed_i, .bin_i,
    .valid_o, .res_o, .sign_o, .ovf_o
  );

  function automatic logic [WT-1:0] to_bcd(input int v);
    logic [WT-1:0] r = '0;
    for (int i = 0; i < ND; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int from_bcd(input logic [WT-1:0] r);
    int v = 0;
    for (int i = ND - 1; i >= 0; i--) v = v * 10 + int'(r[4*i +: 4]);
    return v;
  endfunction

  function automatic exp_t model(input logic [WT-1:0] a, b, input bit add_sub, sm, bn);
    exp_t e;
    int ma, mb, m, lim, full;
    bit s1, s2;
    logic [WT-1:0] ma_raw, mb_raw, magf;
    // R1: sign only when signed mode
    s1 = a[WT-1] & sm;
    s2 = b[WT-1] & sm;
    ma_raw = sm ? {1'b0, a[WT-2:0]} : a;
    mb_raw = sm ? {1'b0, b[WT-2:0]} : b;
    ma = bn ? int'(ma_raw) : from_bcd(ma_raw);
    mb = bn ? int'(mb_raw) : from_bcd(mb_raw);
    // R2
    e.sub = s1 ^ s2 ^ add_sub;
    e.bin = bn;
    full  = bn ? (1 << WT) : 10 ** ND;
    lim   = sm ? (bn ? (1 << (WT-1)) : 8 * 10 ** (ND-1)) : full;
    if (!e.sub) begin
      m = ma + mb;
      e.ovf = (m >= lim);
      m = m % full;
      e.zero = !e.ovf && (m == 0);
      e.sign = e.zero ? 1'b0 : s1;
    end else begin
      e.ovf = 0;
      if (ma > mb)      begin m = ma - mb; e.sign = s1;  end
      else if (ma < mb) begin m = mb - ma; e.sign = !s1; end
      else              begin m = 0;       e.sign = 0;   end
      e.zero = (m == 0);
    end
    magf  = bn ? WT'(m) : to_bcd(m);
    e.res = sm ? {e.sign, magf[WT-2:0]} : magf;
    return e;
  endfunction

  task automatic check_out();
    exp_t e;
    total++;
    if (valid_o !== vh1) begin
      bad++;
      $display("FAIL R10 valid_o act=%b exp=%b", valid_o, vh1);
    end
    if (vh1 && q.size() > 0) begin
      e = q.pop_front();
      total++;
      if (res_o !== e.res) begin
        bad++;
        $display("FAIL %s (R1 R2 R11) res act=%h exp=%h", e.bin ? (e.sub ? "R4" : "R3") : (e.sub ? "R6" : "R5"), res_o, e.res);
      end
      total++;
      if (sign_o !== e.sign) begin
        bad++;
        $display("FAIL %s sign act=%b exp=%b", e.zero ? "R8" : "R7", sign_o, e.sign);
      end
      total++;
      if (ovf_o !== e.ovf) begin
        bad++;
        $display("FAIL R9 ovf act=%b exp=%b", ovf_o, e.ovf);
      end
    end
  endtask

  task automatic issue(input logic [WT-1:0] a, b, input bit s, sm, bn);
    @(negedge clk);
    check_out();
    valid_i = 1; op_a_i = a; op_b_i = b; sub_i = s; signed_i = sm; bin_i = bn;
    q.push_back(model(a, b, s, sm, bn));
    vh1 = vh0; vh0 = 1;
  endtask

  task automatic idle();
    @(negedge clk);
    check_out();
    valid_i = 0;
    op_a_i = ~op_a_i;
    vh1 = vh0; vh0 = 0;
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (valid_o !== 1'b0 || res_o !== '0 || ovf_o !== 1'b0) begin
      bad++;
      $display("FAIL R10 reset valid=%b res=%h ovf=%b exp 0", valid_o, res_o, ovf_o);
    end
    rst_ni = 1;
    // binary sweep: R1 R2 R3 R4 R7 R8 R9 R11
    for (int sm = 0; sm < 2; sm++)
      for (int s = 0; s < 2; s++)
        for (int ia = 0; ia < 32; ia++)
          for (int ib = 0; ib < 32; ib++) begin
            issue(WT'(ia * 8 + ia % 8), WT'(ib * 8 + ib % 8), s[0], sm[0], 1'b1);
            if ((ia + ib) % 7 == 0) idle();
          end
    // decimal sweep: R5 R6 R7 R8 R9 R11
    for (int sm = 0; sm < 2; sm++)
      for (int s = 0; s < 2; s++)
        for (int ia = 0; ia < 25; ia++)
          for (int ib = 0; ib < 25; ib++) begin
            logic [WT-1:0] a, b;
            int va = (ia * 33) % 100, vb = (ib * 33) % 100;
            if (sm == 1) begin
              a = to_bcd(va % 80); a[WT-1] = ia[0];
              b = to_bcd(vb % 80); b[WT-1] = ib[1];
            end else begin
              a = to_bcd(va); b = to_bcd(vb);
            end
            issue(a, b, s[0], sm[0], 1'b0);
            if ((ia + ib) % 5 == 0) idle();
          end
    repeat (3) idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule